// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

The block watches completed data transfers on a 32-bit processor local bus. When the operand of a transfer matches a programmed breakpoint value, it raises a one-clock match flag. The comparison covers only the bits that a programmed mask leaves open. Two independent channels each hold a value register and a mask register. A shared enable register turns each channel on or off. All of these registers are written and read through a small debug-register port selected by a 5-bit register number.

For each transfer the block uses the access size and the two low address bits to pick the active big-endian byte lanes. Only those lanes take part in the comparison, and the lanes of the value register are aligned the same way as the bus lanes. The lane choice covers both aligned and misaligned references, because the address bits that fall below the access size are ignored. Each channel drives its own registered match flag in the cycle after the transfer.

Top module: `dbg_data_bkpt`

## Requirements
- R1: Reset clears both value registers, both mask registers and both enable bits, so every register reads back as zero. `hit` is 0 during reset. No match is reported after reset until software programs the registers.
- R2: Register number 0x0E holds the channel 0 value and 0x0F holds the channel 0 mask. Register number 0x1E holds the channel 1 value and 0x1F holds the channel 1 mask. Register number 0x0D holds the enables, with bit 0 for channel 0 and bit 1 for channel 1. Each of these reads back what was written. Any other register number reads as zero, and writes to it change nothing.
- R3: A mask bit of 1 removes that bit from the comparison. A mask bit of 0 requires the bus bit to equal the value bit.
- R4: Access size 2'b00 (longword) compares all of D[31:0] against all of the value register, whatever the value of A[1:0].
- R5: Access size 2'b10 (word) compares D[31:16] when A[1]=0 and D[15:0] when A[1]=1. A[0] is ignored.
- R6: Access size 2'b01 (byte) compares D[31:24], D[23:16], D[15:8] or D[7:0] for A[1:0] = 00, 01, 10 or 11.
- R7: Bits outside the active lanes never affect the result, whatever the mask holds.
- R8: Access size 2'b11 never produces a match.
- R9: A channel whose enable bit is 0 never raises its match flag.
- R10: `hit[n]` is registered. It is 1 for exactly the one clock that follows a cycle in which `bus_valid` was 1 and channel n matched. It is 0 in any cycle that does not follow a `bus_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Debug register write strobe |
| reg_num | input | 5 | Debug register number |
| reg_wdata | input | 32 | Debug register write data |
| reg_rdata | output | 32 | Debug register read data for the register selected by `reg_num` (combinational) |
| bus_valid | input | 1 | A data transfer completes this cycle |
| bus_addr | input | 2 | Low address bits A[1:0] of the transfer |
| bus_size | input | 2 | Access size: 00 longword, 01 byte, 10 word, 11 invalid |
| bus_data | input | 32 | Transfer data D[31:0] |
| hit | output | 2 | Per-channel match flags, one clock after the transfer |

## Verification
The hardest case to reach from the ports is one in which the active lanes match while the bits outside them would fail a full-width compare. The same applies to misaligned addresses, whose low address bits must be ignored. The vector table sets up this case directly. The channel values are chosen so that each byte and word lane matches one channel and not the other, and the inactive lanes are filled with conflicting data. A second channel with a partial mask shows that masked bits inside an active lane are skipped while unmasked bits in the same lane are still compared.

// File: rtl/dbg_data_bkpt.sv
module dbg_data_bkpt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_num,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        bus_valid,
  input  logic [1:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_data,
  output logic [1:0]  hit
);
  localparam int         NCH     = 2;
  localparam logic [4:0] ENA_NUM = 5'h0D;

  logic [31:0]    val_q [NCH];
  logic [31:0]    msk_q [NCH];
  logic [31:0]    rd    [NCH];
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] cmp;
  logic [31:0]    lanes;

  always_comb begin
    case (bus_size)
      2'b00:   lanes = 32'hFFFF_FFFF;
      2'b01:   lanes = 32'hFF00_0000 >> {bus_addr, 3'b000};
      2'b10:   lanes = bus_addr[1] ? 32'h0000_FFFF : 32'hFFFF_0000;
      default: lanes = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            en_q <= '0;
    else if (reg_we && reg_num == ENA_NUM) en_q <= reg_wdata[NCH-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [4:0] VNUM = 5'(14 + 16 * ch);
    localparam logic [4:0] MNUM = 5'(15 + 16 * ch);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        val_q[ch] <= '0;
        msk_q[ch] <= '0;
      end else if (reg_we) begin
        if (reg_num == VNUM) val_q[ch] <= reg_wdata;
        if (reg_num == MNUM) msk_q[ch] <= reg_wdata;
      end

    assign cmp[ch] = en_q[ch] && (lanes != 32'h0) &&
                     (((bus_data ^ val_q[ch]) & ~msk_q[ch] & lanes) == 32'h0);
    assign rd[ch]  = (reg_num == VNUM) ? val_q[ch] :
                     (reg_num == MNUM) ? msk_q[ch] : 32'h0;
  end

  always_comb begin
    reg_rdata = (reg_num == ENA_NUM) ? {{(32-NCH){1'b0}}, en_q} : 32'h0;
    for (int i = 0; i < NCH; i++) reg_rdata = reg_rdata | rd[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hit <= '0;
    else        hit <= bus_valid ? cmp : '0;
endmodule

// File: rtl/dbg_data_bkpt_chk.sv
module dbg_data_bkpt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic [1:0]  bus_size,
  input logic [1:0]  hit,
  input logic [1:0]  en,
  input logic [31:0] msk0
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (hit == 2'b00 && en == 2'b00));

  assert_fullmask_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && en[0] && msk0 == 32'hFFFF_FFFF && bus_size != 2'b11 |=> hit[0]);

  assert_bad_size_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size == 2'b11 |=> hit == 2'b00);

  assert_ch0_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !en[0] |=> !hit[0]);

  assert_ch1_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !en[1] |=> !hit[1]);

  assert_hit_after_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit != 2'b00 |-> $past(bus_valid));
endmodule

bind dbg_data_bkpt dbg_data_bkpt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_size(bus_size),
  .hit(hit), .en(en_q), .msk0(msk_q[0])
);

// File: tb/dbg_data_bkpt_tb.sv
`timescale 1ns/1ps
module dbg_data_bkpt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_num = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_data = '0;
  logic [1:0]  hit;

  int nvec = 0;
  int nfail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_data_bkpt u_dut (.*);

  // {size, addr, data, expected hit {ch1,ch0}}
  // ch0: value 12345678 mask 00000000; ch1: value CAFE00F0 mask 00FF000F
  localparam logic [37:0] VEC [15] = '{
    {2'b00, 2'b00, 32'h1234_5678, 2'b01},
    {2'b00, 2'b00, 32'hCA00_00F5, 2'b10},
    {2'b00, 2'b11, 32'h1234_5678, 2'b01},
    {2'b10, 2'b00, 32'h1234_FFFF, 2'b01},
    {2'b10, 2'b10, 32'hFFFF_5678, 2'b01},
    {2'b10, 2'b11, 32'h0000_00F3, 2'b10},
    {2'b10, 2'b01, 32'hCA77_0000, 2'b10},
    {2'b01, 2'b00, 32'h1200_0000, 2'b01},
    {2'b01, 2'b01, 32'h0034_0000, 2'b11},
    {2'b01, 2'b10, 32'h0000_5600, 2'b01},
    {2'b01, 2'b11, 32'h0000_00FA, 2'b10},
    {2'b01, 2'b11, 32'h0000_0078, 2'b01},
    {2'b01, 2'b00, 32'hCAFF_FFFF, 2'b10},
    {2'b11, 2'b00, 32'h1234_5678, 2'b00},
    {2'b00, 2'b00, 32'h1234_5679, 2'b00}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 2:          return "R4";
      1:             return "R3";
      3, 4, 5, 6:    return "R5";
      12:            return "R7";
      13:            return "R8";
      14:            return "R4";
      default:       return "R6";
    endcase
  endfunction

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_num = n; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] n, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_num = n;
    #1;
    nvec++;
    if (reg_rdata !== exp) begin
      nfail++;
      $display("FAIL %s reg %h: got %h expected %h", tag, n, reg_rdata, exp);
    end
  endtask

  task automatic xfer_chk(input logic [1:0] sz, input logic [1:0] a, input logic [31:0] d,
                          input logic [1:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_size = sz; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
    nvec++;
    if (hit !== exp) begin
      nfail++;
      $display("FAIL %s size %b addr %b data %h: hit %b expected %b", tag, sz, a, d, hit, exp);
    end
  endtask

  task automatic hit_chk(input logic [1:0] exp, input string tag);
    nvec++;
    if (hit !== exp) begin
      nfail++;
      $display("FAIL %s: hit %b expected %b", tag, hit, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #1;
    hit_chk(2'b00, "R1 hit during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(5'h0E, 32'h0, "R1");
    rd_chk(5'h0F, 32'h0, "R1");
    rd_chk(5'h1E, 32'h0, "R1");
    rd_chk(5'h1F, 32'h0, "R1");
    rd_chk(5'h0D, 32'h0, "R1");
    xfer_chk(2'b00, 2'b00, 32'h0, 2'b00, "R1 unprogrammed");

    wr(5'h0E, 32'h1234_5678);
    wr(5'h0F, 32'h0);
    wr(5'h1E, 32'hCAFE_00F0);
    wr(5'h1F, 32'h00FF_000F);
    wr(5'h0D, 32'h3);
    rd_chk(5'h0E, 32'h1234_5678, "R2");
    rd_chk(5'h1E, 32'hCAFE_00F0, "R2");
    rd_chk(5'h1F, 32'h00FF_000F, "R2");
    rd_chk(5'h0D, 32'h3, "R2");
    wr(5'h05, 32'hDEAD_BEEF);
    rd_chk(5'h05, 32'h0, "R2 unmapped");
    rd_chk(5'h0E, 32'h1234_5678, "R2 unmapped write");

    for (int i = 0; i < 15; i++)
      xfer_chk(VEC[i][37:36], VEC[i][35:34], VEC[i][33:2], VEC[i][1:0], vec_tag(i));

    // R10: no flag without a transfer, and one-clock pulse
    xfer_chk(2'b00, 2'b00, 32'h1234_5678, 2'b01, "R10 pulse");
    @(negedge clk);
    hit_chk(2'b00, "R10 pulse ends");
    @(negedge clk);
    bus_data = 32'h1234_5678; bus_size = 2'b00;
    @(negedge clk);
    hit_chk(2'b00, "R10 no bus_valid");

    // R9: enable gating
    wr(5'h0D, 32'h2);
    xfer_chk(2'b01, 2'b01, 32'h0034_0000, 2'b10, "R9 ch0 off");
    wr(5'h0D, 32'h0);
    xfer_chk(2'b01, 2'b01, 32'h0034_0000, 2'b00, "R9 both off");
    wr(5'h0D, 32'h3);

    // R3: full mask on ch0 matches any data
    wr(5'h0F, 32'hFFFF_FFFF);
    xfer_chk(2'b00, 2'b00, 32'h0BAD_F00D, 2'b01, "R3 full mask");
    xfer_chk(2'b11, 2'b00, 32'h0BAD_F00D, 2'b00, "R8 full mask");

    // R1: reset mid-run clears programming
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(5'h0F, 32'h0, "R1 rerun");
    rd_chk(5'h0D, 32'h0, "R1 rerun");
    xfer_chk(2'b00, 2'b00, 32'h0, 2'b00, "R1 rerun");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule